// File: doc/BRIEF.md
# Energy-metering peripheral bring-up sequencer

This block brings a two-channel energy-metering peripheral from power-on to a configured state. It has no physical link of its own. Each register access is issued on a single-cycle request port (write flag, 8-bit register address, 16-bit data). The block then waits for a one-cycle response strobe carrying the 16-bit read value, or carrying the acknowledge of a write. A frame engine sits between this port and the serial line. A slow tick input, nominally one pulse per second, paces the two opening steps.

On the first tick the block sends the peripheral's reset command. On the next tick it reads the control register and expects its power-on default. It then reads eight factory calibration coefficients from consecutive addresses. It reads one dummy register and then the stored checksum, and compares that checksum with its own running sum. Next it opens write protection and waits a fixed settle interval. It confirms the write-enable status bit, writes three control registers, waits a longer interval and closes write protection. A successful run ends in a sticky found state. Any failed check ends in a sticky fail state with a code that names the check.

The two wait intervals are parameters given in clock cycles. The captured coefficients are presented on a flat output bus for downstream unit conversion.

Top module: `mtr_boot_seq`

## Requirements
- R1: After reset, req_valid, found and failed are low, fail_code is 0, and no request is issued until the first tick pulse.
- R2: On the first tick the block issues a write to address 0xEA with data 0x0096. After that write is acknowledged, no further request is issued until the next tick.
- R3: On the second tick the block reads address 0x00. If the value returned is not 0x0A04, the block stops with failed high and fail_code 1.
- R4: The block reads addresses 0x70 through 0x77 in ascending order. The value read from 0x70+i appears on coef[16*i+15:16*i].
- R5: The block reads 0x6E, discards the value, and then reads 0x6F. The read value must equal the bitwise inverse of (0xFFFF + the sum of the eight coefficients), taken modulo 2^16. Otherwise the block stops with failed high and fail_code 2.
- R6: The block writes 0x00E5 to address 0xEA. It then waits at least WEN_WAIT cycles before it reads address 0x43. If bit 4 of that value is clear, the block stops with failed high and fail_code 3.
- R7: The block then writes 0xFF04 to address 0x00, then 0x1003 to address 0x01, then 0x0FC1 to address 0x13, in that order.
- R8: After the last of those writes is acknowledged, the block waits at least CLOSE_WAIT cycles. It then writes 0x00DC to address 0xEA. When that write is acknowledged, found goes high and stays high.
- R9: req_valid is never high in two consecutive cycles. Each request waits for its response strobe before the next request.
- R10: found and failed are never high together. Once either is high, no further request is issued and fail_code holds. failed is high exactly when fail_code is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pacing pulse (nominally 1 s) |
| req_valid | output | 1 | One-cycle register request strobe |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 8 | Register address |
| req_data | output | 16 | Write data (0 on reads) |
| rsp_valid | input | 1 | One-cycle response / acknowledge strobe |
| rsp_data | input | 16 | Read value returned with rsp_valid |
| found | output | 1 | Bring-up completed |
| failed | output | 1 | Bring-up aborted |
| fail_code | output | 2 | 0 none, 1 default-value mismatch, 2 checksum mismatch, 3 write-enable not set |
| coef | output | 128 | Eight captured 16-bit coefficients, coefficient i in bits 16*i+15:16*i |

## Verification
The bench builds the block with WEN_WAIT = 20 and CLOSE_WAIT = 40. The defaults amount to many millions of cycles. The short values let a full run, including both settle delays, finish within a few hundred cycles. The gap between the write-enable command and the status read, and the gap between the last control write and the close command, can therefore be measured directly against the parameter values. With runs this short, the bench can afford one complete pass plus three aborted passes, one for each failure code.

// File: rtl/mtr_boot_seq.sv
module mtr_boot_seq #(
  parameter int WEN_WAIT   = 800000,
  parameter int CLOSE_WAIT = 8000000,
  parameter int NCOEF      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  output logic                  req_valid,
  output logic                  req_write,
  output logic [7:0]            req_addr,
  output logic [15:0]           req_data,
  input  logic                  rsp_valid,
  input  logic [15:0]           rsp_data,
  output logic                  found,
  output logic                  failed,
  output logic [1:0]            fail_code,
  output logic [16*NCOEF-1:0]   coef
);
  localparam int SW     = 5;
  localparam int CIW    = (NCOEF > 1) ? $clog2(NCOEF) : 1;
  localparam int K_RST  = 0;
  localparam int K_ID   = 1;
  localparam int K_C0   = 2;
  localparam int K_DUM  = K_C0 + NCOEF;
  localparam int K_CHK  = K_DUM + 1;
  localparam int K_OPEN = K_CHK + 1;
  localparam int K_STAT = K_OPEN + 1;
  localparam int K_W0   = K_STAT + 1;
  localparam int K_W1   = K_W0 + 1;
  localparam int K_W2   = K_W1 + 1;
  localparam int K_CLS  = K_W2 + 1;

  typedef enum logic [2:0] {S_TICK, S_REQ, S_RSP, S_WAIT, S_DONE, S_FAIL} st_t;

  st_t           st;
  logic [SW-1:0] step;
  logic [31:0]   cnt, wlim;
  logic [15:0]   sum;
  logic [15:0]   coef_q [NCOEF];
  logic [CIW-1:0] cidx;

  assign cidx = CIW'(step - SW'(K_C0));

  always_comb begin
    req_write = 1'b0;
    req_data  = 16'h0000;
    req_addr  = 8'h00;
    if (int'(step) >= K_C0 && int'(step) < K_DUM) req_addr = 8'h70 + 8'(cidx);
    case (int'(step))
      K_RST:  begin req_write = 1'b1; req_addr = 8'hEA; req_data = 16'h0096; end
      K_DUM:  req_addr = 8'h6E;
      K_CHK:  req_addr = 8'h6F;
      K_OPEN: begin req_write = 1'b1; req_addr = 8'hEA; req_data = 16'h00E5; end
      K_STAT: req_addr = 8'h43;
      K_W0:   begin req_write = 1'b1; req_addr = 8'h00; req_data = 16'hFF04; end
      K_W1:   begin req_write = 1'b1; req_addr = 8'h01; req_data = 16'h1003; end
      K_W2:   begin req_write = 1'b1; req_addr = 8'h13; req_data = 16'h0FC1; end
      K_CLS:  begin req_write = 1'b1; req_addr = 8'hEA; req_data = 16'h00DC; end
      default: ;
    endcase
  end

  assign req_valid = (st == S_REQ);
  assign found     = (st == S_DONE);
  assign failed    = (st == S_FAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_TICK;
      step      <= '0;
      cnt       <= '0;
      wlim      <= 32'd1;
      sum       <= 16'hFFFF;
      fail_code <= 2'd0;
      for (int i = 0; i < NCOEF; i++) coef_q[i] <= 16'h0000;
    end else begin
      case (st)
        S_TICK: if (tick) st <= S_REQ;
        S_REQ:  st <= S_RSP;
        S_WAIT: begin
          cnt <= cnt + 32'd1;
          if (cnt >= wlim - 32'd1) st <= S_REQ;
        end
        S_RSP: if (rsp_valid) begin
          if (int'(step) >= K_C0 && int'(step) < K_DUM) begin
            coef_q[cidx] <= rsp_data;
            sum <= sum + rsp_data;
          end
          if (int'(step) == K_ID && rsp_data != 16'h0A04) begin
            st <= S_FAIL; fail_code <= 2'd1;
          end else if (int'(step) == K_CHK && rsp_data != ~sum) begin
            st <= S_FAIL; fail_code <= 2'd2;
          end else if (int'(step) == K_STAT && !rsp_data[4]) begin
            st <= S_FAIL; fail_code <= 2'd3;
          end else begin
            step <= step + SW'(1);
            cnt  <= '0;
            case (int'(step))
              K_RST:  st <= S_TICK;
              K_OPEN: begin st <= S_WAIT; wlim <= 32'(WEN_WAIT); end
              K_W2:   begin st <= S_WAIT; wlim <= 32'(CLOSE_WAIT); end
              K_CLS:  st <= S_DONE;
              default: st <= S_REQ;
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NCOEF; g++) begin : g_coef
    assign coef[16*g +: 16] = coef_q[g];
  end

  p_single_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(found && failed));
  p_found_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    found |=> found && !req_valid);
  p_fail_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    failed |=> failed && !req_valid && $stable(fail_code));
  p_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    failed == (fail_code != 2'd0));
endmodule

// File: tb/sim_mtr_boot_seq.sv
module sim_mtr_boot_seq;
  localparam int WEN = 20;
  localparam int CLS = 40;
  localparam int NV  = 18;

  localparam logic [24:0] EXP [NV] = '{
    {1'b1, 8'hEA, 16'h0096}, {1'b0, 8'h00, 16'h0000},
    {1'b0, 8'h70, 16'h0000}, {1'b0, 8'h71, 16'h0000},
    {1'b0, 8'h72, 16'h0000}, {1'b0, 8'h73, 16'h0000},
    {1'b0, 8'h74, 16'h0000}, {1'b0, 8'h75, 16'h0000},
    {1'b0, 8'h76, 16'h0000}, {1'b0, 8'h77, 16'h0000},
    {1'b0, 8'h6E, 16'h0000}, {1'b0, 8'h6F, 16'h0000},
    {1'b1, 8'hEA, 16'h00E5}, {1'b0, 8'h43, 16'h0000},
    {1'b1, 8'h00, 16'hFF04}, {1'b1, 8'h01, 16'h1003},
    {1'b1, 8'h13, 16'h0FC1}, {1'b1, 8'hEA, 16'h00DC}};

  logic clk = 0, rst_n = 0, tick = 0;
  logic req_valid, req_write, rsp_valid = 0, found, failed;
  logic [7:0] req_addr;
  logic [15:0] req_data, rsp_data = 0;
  logic [1:0] fail_code;
  logic [127:0] coef;

  always #4 clk = ~clk;

  mtr_boot_seq #(.WEN_WAIT(WEN), .CLOSE_WAIT(CLS), .NCOEF(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .found(found),
    .failed(failed), .fail_code(fail_code), .coef(coef));

  int nchk = 0, nbad = 0, cyc = 0, nlog = 0;
  logic [24:0] lg [32];
  int lcyc [32];
  logic [15:0] m_id, m_chk, m_stat;
  logic [15:0] m_coef [8];
  logic pend = 0;
  logic [7:0] pend_addr;

  function automatic logic [15:0] model_rd(input logic [7:0] a);
    if (a >= 8'h70 && a <= 8'h77) return m_coef[a[2:0]];
    case (a)
      8'h00: return m_id;
      8'h6E: return 16'h5A5A;
      8'h6F: return m_chk;
      8'h43: return m_stat;
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rsp_valid <= 1'b0;
    if (pend) begin
      rsp_valid <= 1'b1;
      rsp_data  <= model_rd(pend_addr);
      pend <= 1'b0;
    end
    if (req_valid) begin
      if (nlog < 32) begin
        lg[nlog]   <= {req_write, req_addr, req_write ? req_data : 16'h0000};
        lcyc[nlog] <= cyc;
      end
      nlog <= nlog + 1;
      pend <= 1'b1;
      pend_addr <= req_addr;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic run(input logic [15:0] id, input logic bad_chk, input logic [15:0] st);
    logic [15:0] s;
    m_id = id; m_stat = st;
    s = 16'hFFFF;
    for (int i = 0; i < 8; i++) begin
      m_coef[i] = 16'h1111 * 16'(i + 1) + 16'h0A0B;
      s = s + m_coef[i];
    end
    m_chk = bad_chk ? ~s ^ 16'h0001 : ~s;
    rst_n = 0;
    repeat (3) @(negedge clk);
    nlog = 0;
    rst_n = 1;
    repeat (30) @(negedge clk);
    chk("R1 no request before tick", nlog, 0);
    chk("R1 found/failed/code after reset", {found, failed, fail_code}, 0);
    pulse_tick();
    repeat (30) @(negedge clk);
    chk("R2 held after reset command", nlog, 1);
    pulse_tick();
    for (int i = 0; i < 2000 && !found && !failed; i++) @(negedge clk);
  endtask

  initial begin
    run(16'h0A04, 1'b0, 16'h0010);
    chk("R8 found after close", found, 1);
    chk("R10 no fail code on success", {failed, fail_code}, 0);
    chk("R9 request count", nlog, NV);
    for (int i = 0; i < NV; i++)
      chk(i == 0 ? "R2 reset cmd" : i == 1 ? "R3 id read" : i < 10 ? "R4 coef read" :
          i < 12 ? "R5 checksum reads" : i < 14 ? "R6 open/status" :
          i < 17 ? "R7 config write" : "R8 close cmd", 32'(lg[i]), 32'(EXP[i]));
    for (int i = 0; i < 8; i++)
      chk("R4 coef capture", 32'(coef[16*i +: 16]), 32'(m_coef[i]));
    chk("R6 settle gap", 32'(lcyc[13] - lcyc[12] > WEN), 1);
    chk("R8 close gap", 32'(lcyc[17] - lcyc[16] > CLS), 1);
    for (int i = 1; i < NV; i++)
      if (lcyc[i] - lcyc[i-1] < 3) chk("R9 response before next request", i, 0);
    repeat (20) @(negedge clk);
    chk("R10 no request after found", nlog, NV);

    run(16'h0A05, 1'b0, 16'h0010);
    chk("R3 default mismatch code", {failed, fail_code}, {1'b1, 2'd1});
    chk("R3 stops after id read", nlog, 2);

    run(16'h0A04, 1'b1, 16'h0010);
    chk("R5 checksum mismatch code", {failed, fail_code}, {1'b1, 2'd2});
    chk("R5 stops after checksum read", nlog, 12);

    run(16'h0A04, 1'b0, 16'hFFEF);
    chk("R6 status bit clear code", {failed, fail_code}, {1'b1, 2'd3});
    repeat (20) @(negedge clk);
    chk("R10 no request after fail", nlog, 14);
    chk("R10 code holds", fail_code, 3);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog expired R1..R10 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule